// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns an indexed-addressing post-byte into a final operand address. A one-cycle `start` pulse presents the post-byte, the extension word, the four pointer registers, the program counter and both 8-bit accumulators. From the post-byte the block picks a base register and an offset kind. The offset can be a short signed constant, an 8-bit or 16-bit constant, an accumulator value, an auto-increment or auto-decrement step, a displacement from the program counter, or an absolute pointer. The block adds the offset to the base. If the mode asks for it, the block then reads one pointer from memory as two bytes and uses that pointer as the final address.

The result appears on `ea` with a one-cycle `done` pulse. With the same pulse, the block reports the new base value for auto-step modes. In load-effective-address use it also reports the final address as a write into a chosen pointer register. Opcode decoding and the execution that consumes the operand belong to the surrounding core. The extension word holds an 8-bit value in its low byte or a full 16-bit value.

Top module: `idxgen_top`

## Requirements
- R1: When post-byte bit 7 is 0, the address is the base register plus bits 4:0 taken as a signed value (-16..15). Bits 6:5 select the base register: 00 X, 01 Y, 10 U, 11 S. This form never reads memory, and `done` rises in the cycle after `start`.
- R2: With bit 7 set, bits 6:5 select the base and bits 3:0 select the mode. Mode 4 uses the base with no offset. Mode 8 adds ext[7:0] sign-extended. Mode 9 adds the full 16-bit ext.
- R3: Mode 6 adds A sign-extended, mode 5 adds B sign-extended, and mode 11 adds D = {A,B} as a signed 16-bit value.
- R4: Modes 0 and 1 use the old base as the address and then step it by +1 and +2. Modes 2 and 3 step the base by -1 and -2 and use the stepped value as the address. In all four, the stepped base is reported on `base_wr_en`/`base_wr_sel`/`base_wr_val` together with `done`.
- R5: Modes 12 and 13 add ext[7:0] sign-extended, or the full ext, to PC. The register field plays no part, and no base write is reported.
- R6: Mode 15 treats ext as an absolute pointer and always reads exactly one two-byte word from it, whatever bit 4 says. The word read is the final address, and no second read follows.
- R7: In every other bit-7-set mode, bit 4 requests indirection on the computed address. The block reads the high byte at that address and the low byte at the next address (wrapping at 16 bits). `ea` becomes {high, low}, and `done` rises in the cycle after the second acknowledge.
- R8: When `lea_en` is high at `start`, the final address is also reported on `lea_wr_en`/`lea_wr_val` with `done`. `lea_wr_sel` equals `lea_dst` (00 X, 01 Y, 10 U, 11 S). When `lea_en` is low, `lea_wr_en` stays low.
- R9: Unused modes 7, 10 and 14 behave as mode 4.
- R10: A `start` that arrives while `busy` is high is ignored. The result and the number of `done` pulses are those of the transfer already in progress.
- R11: After reset, `done`, `busy`, `mem_req`, `base_wr_en` and `lea_wr_en` are low.
- R12: While `mem_req` is high without `mem_ack`, the request stays high and `mem_addr` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address generation |
| postbyte | input | 8 | Mode post-byte |
| ext | input | 16 | Extension bytes (8-bit value in low byte) |
| lea_en | input | 1 | Load-effective-address use |
| lea_dst | input | 2 | Destination pointer for load-effective-address |
| reg_x | input | 16 | Pointer X |
| reg_y | input | 16 | Pointer Y |
| reg_u | input | 16 | Pointer U |
| reg_s | input | 16 | Pointer S |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| busy | output | 1 | Indirect read in progress |
| done | output | 1 | One-cycle result pulse |
| ea | output | 16 | Final address, held until the next result |
| base_wr_en | output | 1 | Base register update valid |
| base_wr_sel | output | 2 | Base register to update |
| base_wr_val | output | 16 | New base value |
| lea_wr_en | output | 1 | Load-effective-address write valid |
| lea_wr_sel | output | 2 | Destination pointer |
| lea_wr_val | output | 16 | Value to write |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read byte |

## Verification
The hardest situations to reach are indirect transfers whose memory acknowledges arrive late, and a second `start` that lands while such a transfer is waiting. The bench sweeps all 256 post-bytes against three register sets. These sets include values that wrap around zero and accumulators with the sign bit set. Each sweep runs with and without load-effective-address use, and the responder latency changes from one transfer to the next. A separate sequence sets a three-cycle latency and pulses `start` with a different post-byte in the middle of a read. It then checks that the first result and a single `done` survive.

// File: rtl/idxgen_pkg.sv
package idxgen_pkg;

  typedef enum logic [2:0] {
    BASE_X    = 3'd0,
    BASE_Y    = 3'd1,
    BASE_U    = 3'd2,
    BASE_S    = 3'd3,
    BASE_PC   = 3'd4,
    BASE_NONE = 3'd5
  } base_e;

  localparam logic [3:0] M_POST1  = 4'd0;
  localparam logic [3:0] M_POST2  = 4'd1;
  localparam logic [3:0] M_PRE1   = 4'd2;
  localparam logic [3:0] M_PRE2   = 4'd3;
  localparam logic [3:0] M_ZERO   = 4'd4;
  localparam logic [3:0] M_ACCB   = 4'd5;
  localparam logic [3:0] M_ACCA   = 4'd6;
  localparam logic [3:0] M_OFF8   = 4'd8;
  localparam logic [3:0] M_OFF16  = 4'd9;
  localparam logic [3:0] M_ACCD   = 4'd11;
  localparam logic [3:0] M_PCR8   = 4'd12;
  localparam logic [3:0] M_PCR16  = 4'd13;
  localparam logic [3:0] M_EXTIND = 4'd15;

endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idxgen_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [7:0]    pb,
  input  logic [AW-1:0] ext,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  output base_e         base_sel,
  output logic [AW-1:0] offset,
  output logic          indirect,
  output logic          wb_en,
  output logic [AW-1:0] wb_delta
);

  localparam logic [AW-1:0] STEP_P1 = AW'(1);
  localparam logic [AW-1:0] STEP_P2 = AW'(2);
  localparam logic [AW-1:0] STEP_M1 = {AW{1'b1}};
  localparam logic [AW-1:0] STEP_M2 = {{(AW-2){1'b1}}, 2'b10};

  logic [AW-1:0] sx5, sx_ext8, sx_a, sx_b;
  base_e         reg_sel;

  assign sx5     = {{(AW-5){pb[4]}}, pb[4:0]};
  assign sx_ext8 = {{(AW-DW){ext[DW-1]}}, ext[DW-1:0]};
  assign sx_a    = {{(AW-DW){acc_a[DW-1]}}, acc_a};
  assign sx_b    = {{(AW-DW){acc_b[DW-1]}}, acc_b};
  assign reg_sel = base_e'({1'b0, pb[6:5]});

  always_comb begin
    base_sel = reg_sel;
    offset   = '0;
    indirect = 1'b0;
    wb_en    = 1'b0;
    wb_delta = '0;
    if (!pb[7]) begin
      offset = sx5;
    end else begin
      indirect = pb[4];
      case (pb[3:0])
        M_POST1: begin wb_en = 1'b1; wb_delta = STEP_P1; end
        M_POST2: begin wb_en = 1'b1; wb_delta = STEP_P2; end
        M_PRE1:  begin wb_en = 1'b1; wb_delta = STEP_M1; offset = STEP_M1; end
        M_PRE2:  begin wb_en = 1'b1; wb_delta = STEP_M2; offset = STEP_M2; end
        M_ACCB:  offset = sx_b;
        M_ACCA:  offset = sx_a;
        M_OFF8:  offset = sx_ext8;
        M_OFF16: offset = ext;
        M_ACCD:  offset = {acc_a, acc_b};
        M_PCR8:  begin base_sel = BASE_PC; offset = sx_ext8; end
        M_PCR16: begin base_sel = BASE_PC; offset = ext; end
        M_EXTIND: begin
          base_sel = BASE_NONE;
          offset   = ext;
          indirect = 1'b1;
        end
        default: offset = '0;
      endcase
    end
  end

endmodule

// File: rtl/idx_sum.sv
module idx_sum
  import idxgen_pkg::*;
#(
  parameter int AW = 16
) (
  input  base_e         base_sel,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_u,
  input  logic [AW-1:0] reg_s,
  input  logic [AW-1:0] reg_pc,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] wb_delta,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val
);

  logic [AW-1:0] base_val;

  always_comb begin
    case (base_sel)
      BASE_X:  base_val = reg_x;
      BASE_Y:  base_val = reg_y;
      BASE_U:  base_val = reg_u;
      BASE_S:  base_val = reg_s;
      BASE_PC: base_val = reg_pc;
      default: base_val = '0;
    endcase
  end

  assign addr   = base_val + offset;
  assign wb_val = base_val + wb_delta;

endmodule

// File: rtl/idx_fetch.sv
module idx_fetch #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] ptr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          fin,
  output logic [AW-1:0] word
);

  localparam int NB = AW / DW;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NB - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] word_q, word_d;
  logic          take_byte;

  assign take_byte = active_q & mem_ack;
  assign mem_req   = active_q;
  assign mem_addr  = ptr_q + {{(AW-CW){1'b0}}, cnt_q};
  assign word      = {word_q[AW-DW-1:0], mem_rdata};
  assign fin       = take_byte & (cnt_q == LAST);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    word_d   = word_q;
    if (go && !active_q) begin
      active_d = 1'b1;
      cnt_d    = '0;
      ptr_d    = ptr;
    end else if (take_byte) begin
      word_d = word;
      if (cnt_q == LAST) active_d = 1'b0;
      else               cnt_d    = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      word_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      ptr_q    <= ptr_d;
      word_q   <= word_d;
    end
  end

endmodule

// File: rtl/idxgen_top.sv
module idxgen_top
  import idxgen_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [AW-1:0] ext,
  input  logic          lea_en,
  input  logic [1:0]    lea_dst,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_u,
  input  logic [AW-1:0] reg_s,
  input  logic [AW-1:0] reg_pc,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          base_wr_en,
  output logic [1:0]    base_wr_sel,
  output logic [AW-1:0] base_wr_val,
  output logic          lea_wr_en,
  output logic [1:0]    lea_wr_sel,
  output logic [AW-1:0] lea_wr_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  base_e         base_sel;
  logic [AW-1:0] offset, wb_delta, addr, wb_val, word;
  logic          indirect, wb_en, fin;
  logic          take, go_fetch, direct_fin;

  idx_decode #(.DW(DW)) u_decode (
    .pb       (postbyte),
    .ext      (ext),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .base_sel (base_sel),
    .offset   (offset),
    .indirect (indirect),
    .wb_en    (wb_en),
    .wb_delta (wb_delta)
  );

  idx_sum #(.AW(AW)) u_sum (
    .base_sel (base_sel),
    .reg_x    (reg_x),
    .reg_y    (reg_y),
    .reg_u    (reg_u),
    .reg_s    (reg_s),
    .reg_pc   (reg_pc),
    .offset   (offset),
    .wb_delta (wb_delta),
    .addr     (addr),
    .wb_val   (wb_val)
  );

  idx_fetch #(.DW(DW), .AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_fetch),
    .ptr       (addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .fin       (fin),
    .word      (word)
  );

  assign busy       = mem_req;
  assign take       = start & ~busy;
  assign go_fetch   = take & indirect;
  assign direct_fin = take & ~indirect;

  // side information held across an indirect read
  logic          h_wbe_q, h_wbe_d;
  logic [1:0]    h_wbs_q, h_wbs_d;
  logic [AW-1:0] h_wbv_q, h_wbv_d;
  logic          h_lea_q, h_lea_d;
  logic [1:0]    h_dst_q, h_dst_d;

  // result registers
  logic          done_d, bwe_d, lwe_d;
  logic [AW-1:0] ea_d, bwv_d;
  logic [1:0]    bws_d, lws_d;
  logic          res_ce;

  always_comb begin
    h_wbe_d = h_wbe_q;
    h_wbs_d = h_wbs_q;
    h_wbv_d = h_wbv_q;
    h_lea_d = h_lea_q;
    h_dst_d = h_dst_q;
    if (go_fetch) begin
      h_wbe_d = wb_en;
      h_wbs_d = postbyte[6:5];
      h_wbv_d = wb_val;
      h_lea_d = lea_en;
      h_dst_d = lea_dst;
    end
  end

  always_comb begin
    done_d = direct_fin | fin;
    res_ce = done_d;
    ea_d   = fin ? word : addr;
    bwe_d  = fin ? h_wbe_q : (direct_fin & wb_en);
    bws_d  = fin ? h_wbs_q : postbyte[6:5];
    bwv_d  = fin ? h_wbv_q : wb_val;
    lwe_d  = fin ? h_lea_q : (direct_fin & lea_en);
    lws_d  = fin ? h_dst_q : lea_dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_wbe_q <= 1'b0;
      h_wbs_q <= '0;
      h_wbv_q <= '0;
      h_lea_q <= 1'b0;
      h_dst_q <= '0;
    end else begin
      h_wbe_q <= h_wbe_d;
      h_wbs_q <= h_wbs_d;
      h_wbv_q <= h_wbv_d;
      h_lea_q <= h_lea_d;
      h_dst_q <= h_dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      base_wr_en  <= 1'b0;
      lea_wr_en   <= 1'b0;
      ea          <= '0;
      base_wr_sel <= '0;
      base_wr_val <= '0;
      lea_wr_sel  <= '0;
      lea_wr_val  <= '0;
    end else begin
      done       <= done_d;
      base_wr_en <= bwe_d & done_d;
      lea_wr_en  <= lwe_d & done_d;
      if (res_ce) begin
        ea          <= ea_d;
        base_wr_sel <= bws_d;
        base_wr_val <= bwv_d;
        lea_wr_sel  <= lws_d;
        lea_wr_val  <= ea_d;
      end
    end
  end

endmodule

// File: rtl/idxgen_chk.sv
module idxgen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    postbyte,
  input logic [AW-1:0] ext,
  input logic          busy,
  input logic          done,
  input logic          base_wr_en,
  input logic          lea_wr_en,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);

  // R1
  short_form_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !postbyte[7]) |=> (done && !mem_req && !busy));

  // R5
  pc_rel_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && postbyte[7] && !postbyte[4] &&
     (postbyte[3:0] == 4'd12 || postbyte[3:0] == 4'd13)) |=> (done && !base_wr_en));

  // R6
  ext_ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && postbyte[7] && postbyte[3:0] == 4'hF)
      |=> (mem_req && mem_addr == $past(ext)));

  // R7
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> !done);

  // R8
  writes_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_en || lea_wr_en) |-> done);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

bind idxgen_top idxgen_chk #(.AW(AW)) u_idxgen_chk (.*);

// File: tb/test_idxgen_top.sv
module test_idxgen_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [15:0] ext = '0;
  logic        lea_en = 1'b0;
  logic [1:0]  lea_dst = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, reg_pc = '0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic        busy, done, base_wr_en, lea_wr_en, mem_req;
  logic [15:0] ea, base_wr_val, lea_wr_val, mem_addr;
  logic [1:0]  base_wr_sel, lea_wr_sel;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wcnt = 0;
  int acks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  idxgen_top i_idxgen_top (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte), .ext(ext),
    .lea_en(lea_en), .lea_dst(lea_dst), .reg_x(reg_x), .reg_y(reg_y),
    .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
    .busy(busy), .done(done), .ea(ea), .base_wr_en(base_wr_en),
    .base_wr_sel(base_wr_sel), .base_wr_val(base_wr_val), .lea_wr_en(lea_wr_en),
    .lea_wr_sel(lea_wr_sel), .lea_wr_val(lea_wr_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory responder, updated away from the active edge
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = memf(mem_addr);
        acks      = acks + 1;
        wcnt      = 0;
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sx8(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  // address model built from the requirements
  task automatic model(input logic [7:0] pb, output logic [15:0] adr, output logic ind,
                       output logic wbe, output logic [15:0] wbv, output string tag);
    logic [15:0] b;
    case (pb[6:5])
      2'd0: b = reg_x;
      2'd1: b = reg_y;
      2'd2: b = reg_u;
      default: b = reg_s;
    endcase
    ind = 1'b0; wbe = 1'b0; wbv = '0;
    if (!pb[7]) begin
      adr = b + {{11{pb[4]}}, pb[4:0]};
      tag = "R1";
    end else begin
      ind = pb[4];
      case (pb[3:0])
        4'd0:  begin adr = b; wbe = 1'b1; wbv = b + 16'd1; tag = "R4"; end
        4'd1:  begin adr = b; wbe = 1'b1; wbv = b + 16'd2; tag = "R4"; end
        4'd2:  begin adr = b - 16'd1; wbe = 1'b1; wbv = b - 16'd1; tag = "R4"; end
        4'd3:  begin adr = b - 16'd2; wbe = 1'b1; wbv = b - 16'd2; tag = "R4"; end
        4'd4:  begin adr = b; tag = "R2"; end
        4'd8:  begin adr = b + sx8(ext[7:0]); tag = "R2"; end
        4'd9:  begin adr = b + ext; tag = "R2"; end
        4'd5:  begin adr = b + sx8(acc_b); tag = "R3"; end
        4'd6:  begin adr = b + sx8(acc_a); tag = "R3"; end
        4'd11: begin adr = b + {acc_a, acc_b}; tag = "R3"; end
        4'd12: begin adr = reg_pc + sx8(ext[7:0]); tag = "R5"; end
        4'd13: begin adr = reg_pc + ext; tag = "R5"; end
        4'd15: begin adr = ext; ind = 1'b1; tag = "R6"; end
        default: begin adr = b; tag = "R9"; end
      endcase
    end
  endtask

  task automatic run_one(input logic [7:0] pb, input logic le, input logic [1:0] dst,
                         input int l);
    logic [15:0] adr, wbv, fin_adr;
    logic        ind, wbe;
    string       tag, rtag;
    int          n;
    model(pb, adr, ind, wbe, wbv, tag);
    fin_adr = ind ? {memf(adr), memf(adr + 16'd1)} : adr;
    rtag    = (ind && tag != "R6") ? "R7" : tag;
    @(negedge clk);
    lat = l; acks = 0;
    postbyte = pb; lea_en = le; lea_dst = dst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      @(negedge clk);
      n = n + 1;
    end
    chk(done, "R7", "done watchdog", 32'(n), 32'd60);
    if (!ind) chk(n == 1, tag, "direct latency", 32'(n), 32'd1);
    chk(ea == fin_adr, rtag, $sformatf("ea pb=%h", pb), 32'(ea), 32'(fin_adr));
    chk(acks == (ind ? 2 : 0), rtag, $sformatf("byte reads pb=%h", pb), 32'(acks),
        ind ? 32'd2 : 32'd0);
    if (wbe)
      chk(base_wr_en && base_wr_sel == pb[6:5] && base_wr_val == wbv, "R4",
          $sformatf("base write pb=%h", pb), {base_wr_en, 13'd0, base_wr_sel, base_wr_val},
          {1'b1, 13'd0, pb[6:5], wbv});
    else
      chk(!base_wr_en, tag, $sformatf("no base write pb=%h", pb), 32'(base_wr_en), 32'd0);
    if (le)
      chk(lea_wr_en && lea_wr_sel == dst && lea_wr_val == fin_adr, "R8",
          $sformatf("lea write pb=%h", pb), {lea_wr_en, 13'd0, lea_wr_sel, lea_wr_val},
          {1'b1, 13'd0, dst, fin_adr});
    else
      chk(!lea_wr_en, "R8", $sformatf("no lea write pb=%h", pb), 32'(lea_wr_en), 32'd0);
  endtask

  task automatic load_set(input int k);
    case (k)
      0: begin reg_x = 16'h1000; reg_y = 16'h2345; reg_u = 16'h8000; reg_s = 16'hFFFF;
               reg_pc = 16'h0100; acc_a = 8'h7F; acc_b = 8'h80; ext = 16'h8005; end
      1: begin reg_x = 16'h0000; reg_y = 16'h7FFF; reg_u = 16'hABCD; reg_s = 16'h0001;
               reg_pc = 16'hFFF0; acc_a = 8'h80; acc_b = 8'h01; ext = 16'h12F0; end
      default: begin reg_x = 16'hFFFE; reg_y = 16'h4000; reg_u = 16'h0010; reg_s = 16'hC350;
               reg_pc = 16'h7FF8; acc_a = 8'hFF; acc_b = 8'hFF; ext = 16'h7FFF; end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !busy && !mem_req && !base_wr_en && !lea_wr_en, "R11", "reset outputs",
        {27'd0, done, busy, mem_req, base_wr_en, lea_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 3; k++) begin
      load_set(k);
      for (int p = 0; p < 256; p++) begin
        for (int le = 0; le < 2; le++) begin
          run_one(8'(p), le[0], 2'(p[1:0] ^ k[1:0]), (p + k + le) % 4);
        end
      end
    end

    // R10: a start during an indirect read is ignored
    begin
      logic [15:0] exp_w;
      int          nd;
      load_set(0);
      exp_w = {memf(reg_x), memf(reg_x + 16'd1)};
      @(negedge clk);
      lat = 3; acks = 0;
      postbyte = 8'h94; lea_en = 1'b0; start = 1'b1;
      @(negedge clk);
      postbyte = 8'h01; lea_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nd = 0;
      for (int c = 0; c < 40; c++) begin
        if (done) nd = nd + 1;
        if (done) chk(ea == exp_w, "R10", "result of first transfer", 32'(ea), 32'(exp_w));
        if (done) chk(!lea_wr_en, "R10", "second start leaked", 32'(lea_wr_en), 32'd0);
        @(negedge clk);
      end
      chk(nd == 1, "R10", "done pulse count", 32'(nd), 32'd1);
      chk(acks == 2, "R10", "byte reads", 32'(acks), 32'd2);
    end

    finish_run();
  end

endmodule